// File: doc/BRIEF.md
# Serial Channel Status Flags

This block keeps the status of one serial channel. A separate shift engine sends it single-cycle event strobes: a transmission starting, a byte finished on the line, and a reception finished. With the reception strobe come the received byte, the sampled stop bit and the received parity bit. Mode inputs say whether the channel is asynchronous or clock-synchronized, master or slave, and whether parity is on and whether it is odd.

From these the block keeps a transmit-busy flag, three error flags (framing, parity, overrun) and a receive-data-full indicator. It also holds the receive data register. The CPU sees all flags in one byte-wide status word. It clears error flags by writing zeros to their bit positions. It consumes received data with a read strobe. Every flag and the data register are registered, so an event shows in the outputs one clock after its strobe.

Top module: `ser_stat_flags`

## Requirements
- R1: After reset the status word is 8'h00 and the receive data register is 8'h00. A busy flag of 0 means transmission has ended.
- R2: Status bit 5 (transmit busy) becomes 1 the cycle after a `tx_start` strobe. CPU writes never change it, and a start wins over a byte-done strobe in the same cycle.
- R3: In asynchronous mode and in clock-synchronized master mode, a `tx_byte_done` strobe with `tx_pending` high leaves bit 5 at 1. With `tx_pending` low it clears bit 5.
- R4: In clock-synchronized slave mode (`mode_async`=0, `mode_master`=0), every `tx_byte_done` strobe clears bit 5, whatever `tx_pending` is.
- R5: Status bit 4 (framing error) is set when a reception completes in asynchronous mode with the sampled stop bit equal to 0.
- R6: Status bit 3 (parity error) is set when a reception completes in asynchronous mode with `par_en`=1 and the parity is wrong. With `par_odd`=0 the data bits plus the parity bit must hold an even number of ones. With `par_odd`=1 they must hold an odd number.
- R7: Status bit 2 (overrun error) is set when a reception completes while bit 0 is 1 and no read strobe is present that cycle. The new byte still overwrites the receive data register.
- R8: Every completed reception loads `rx_data` into the receive data register and sets status bit 0 (data full). A `cpu_rd` strobe clears bit 0. A read in the same cycle as a reception counts as taking the old byte, so bit 0 stays 1 and no overrun is flagged.
- R9: A `cpu_wr` strobe clears each error flag whose bit in `cpu_wdata` is 0. A 1 in that bit leaves the flag unchanged.
- R10: If an error event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R11: While `rx_en` and `tx_en` are both 0, all three error flags are forced to 0 and error events are ignored.
- R12: In clock-synchronized mode, the framing and parity flags are never set, even with a 0 stop bit or a wrong parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | 1 = asynchronous, 0 = clock-synchronized |
| mode_master | input | 1 | 1 = master, 0 = slave (synchronous mode) |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| tx_start | input | 1 | Strobe: a transmission begins |
| tx_byte_done | input | 1 | Strobe: a byte has been shifted out |
| tx_pending | input | 1 | More transmit data is queued |
| rx_done | input | 1 | Strobe: a reception is complete |
| rx_data | input | 8 | Received byte, valid with `rx_done` |
| rx_stop | input | 1 | Sampled stop bit, valid with `rx_done` |
| rx_par | input | 1 | Received parity bit, valid with `rx_done` |
| cpu_wr | input | 1 | Status write strobe |
| cpu_wdata | input | 8 | Status write data |
| cpu_rd | input | 1 | Receive data register read strobe |
| status | output | 8 | Status: bit5 busy, bit4 framing, bit3 parity, bit2 overrun, bit0 full |
| rx_dreg | output | 8 | Receive data register |

## Verification
The assertions assume the strobes last one cycle. They also assume the mode inputs do not change in the cycle an event is judged, since each check reads the mode sampled alongside its strobe. The bench changes mode and enable inputs only on cycles that carry no strobe, except where a test deliberately pairs an event with the disabled state. It sets `rx_data`, `rx_stop` and `rx_par` together with `rx_done`.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int BUSY_BIT = 5;
  localparam int ERR_LSB  = 2;   // overrun, then parity, then framing
  localparam int NERR     = 3;
  localparam int FULL_BIT = 0;

  typedef enum logic [1:0] {E_OVR = 2'd0, E_PAR = 2'd1, E_FRM = 2'd2} err_idx_e;

  // 1 when the received parity bit disagrees with the chosen sense
  function automatic logic par_fail(input logic [7:0] d, input logic pbit, input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction
endpackage

// File: rtl/ser_txbusy.sv
module ser_txbusy (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_async,
  input  logic mode_master,
  input  logic tx_start,
  input  logic tx_byte_done,
  input  logic tx_pending,
  output logic busy
);
  logic slave_sync;
  logic drop;
  assign slave_sync = !mode_async && !mode_master;
  assign drop = tx_byte_done && (slave_sync || !tx_pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (tx_start) busy <= 1'b1;
    else if (drop)     busy <= 1'b0;
  end
endmodule

// File: rtl/ser_rxcheck.sv
module ser_rxcheck #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_async,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_stop,
  input  logic          rx_par,
  input  logic          cpu_rd,
  output logic          frm_evt,
  output logic          par_evt,
  output logic          ovr_evt,
  output logic          full,
  output logic [DW-1:0] dreg
);
  import ser_stat_pkg::*;
  logic [7:0] d8;
  assign d8 = 8'(rx_data);

  assign frm_evt = rx_done && mode_async && !rx_stop;
  assign par_evt = rx_done && mode_async && par_en && par_fail(d8, rx_par, par_odd);
  assign ovr_evt = rx_done && full && !cpu_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dreg <= '0;
    end else if (rx_done) begin
      full <= 1'b1;
      dreg <= rx_data;
    end else if (cpu_rd) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_errflags.sv
module ser_errflags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         all_off,
  input  logic [N-1:0] set_evt,
  input  logic         cpu_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flags[i] <= 1'b0;
      else if (all_off)                flags[i] <= 1'b0;
      else if (set_evt[i])             flags[i] <= 1'b1;
      else if (cpu_wr && !wbits[i])    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
  import ser_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_async,
  input  logic          mode_master,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          tx_start,
  input  logic          tx_byte_done,
  input  logic          tx_pending,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_stop,
  input  logic          rx_par,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_rd,
  output logic [7:0]    status,
  output logic [DW-1:0] rx_dreg
);
  logic            busy;
  logic            frm_evt, par_evt, ovr_evt;
  logic            full;
  logic            all_off;
  logic [NERR-1:0] err_set;
  logic [NERR-1:0] err_q;
  logic            unused_wbits;

  assign all_off      = !rx_en && !tx_en;
  assign unused_wbits = ^{cpu_wdata[7:ERR_LSB+NERR], cpu_wdata[ERR_LSB-1:0]};

  ser_txbusy u_busy (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .mode_master(mode_master),
    .tx_start(tx_start), .tx_byte_done(tx_byte_done), .tx_pending(tx_pending),
    .busy(busy)
  );

  ser_rxcheck #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .par_en(par_en),
    .par_odd(par_odd), .rx_done(rx_done), .rx_data(rx_data), .rx_stop(rx_stop),
    .rx_par(rx_par), .cpu_rd(cpu_rd), .frm_evt(frm_evt), .par_evt(par_evt),
    .ovr_evt(ovr_evt), .full(full), .dreg(rx_dreg)
  );

  always_comb begin
    err_set        = '0;
    err_set[E_OVR] = ovr_evt;
    err_set[E_PAR] = par_evt;
    err_set[E_FRM] = frm_evt;
  end

  ser_errflags #(.N(NERR)) u_err (
    .clk(clk), .rst_n(rst_n), .all_off(all_off), .set_evt(err_set),
    .cpu_wr(cpu_wr), .wbits(cpu_wdata[ERR_LSB +: NERR]), .flags(err_q)
  );

  always_comb begin
    status                   = '0;
    status[BUSY_BIT]         = busy;
    status[ERR_LSB +: NERR]  = err_q;
    status[FULL_BIT]         = full;
  end
endmodule

// File: rtl/ser_stat_chk.sv
module ser_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_async,
  input logic       mode_master,
  input logic       rx_en,
  input logic       tx_en,
  input logic       tx_start,
  input logic       tx_byte_done,
  input logic       tx_pending,
  input logic       rx_done,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic       cpu_rd,
  input logic [7:0] status,
  input logic       frm_evt,
  input logic       ovr_evt
);
  logic en_any;
  assign en_any = rx_en || tx_en;

  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> status[5]);
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_done && tx_pending && !tx_start && (mode_async || mode_master) && status[5]) |=> status[5]);
  a_r4_slave_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_done && !tx_start && !mode_async && !mode_master) |=> !status[5]);
  a_r5_frm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_evt && en_any) |=> status[4]);
  a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && en_any) |=> status[2]);
  a_r8_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> status[0]);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !rx_done) |=> !status[0]);
  a_r9_wr1_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wdata[4] && status[4] && en_any) |=> status[4]);
  a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !tx_en) |=> (status[4:2] == 3'b000));
  a_r12_sync_no_frm: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_async && !status[4]) |=> !status[4]);
endmodule

bind ser_stat_flags ser_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .mode_master(mode_master),
  .rx_en(rx_en), .tx_en(tx_en), .tx_start(tx_start), .tx_byte_done(tx_byte_done),
  .tx_pending(tx_pending), .rx_done(rx_done), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .status(status), .frm_evt(frm_evt), .ovr_evt(ovr_evt)
);

// File: tb/tb_ser_stat_flags.sv
module tb_ser_stat_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_async = 1'b1, mode_master = 1'b0, par_en = 1'b1, par_odd = 1'b0;
  logic rx_en = 1'b1, tx_en = 1'b1;
  logic tx_start = 1'b0, tx_byte_done = 1'b0, tx_pending = 1'b0;
  logic rx_done = 1'b0, rx_stop = 1'b1, rx_par = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] status, rx_dreg;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [7:0] st;
    logic [7:0] d;
    string      req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ser_stat_flags dut (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .mode_master(mode_master),
    .par_en(par_en), .par_odd(par_odd), .rx_en(rx_en), .tx_en(tx_en),
    .tx_start(tx_start), .tx_byte_done(tx_byte_done), .tx_pending(tx_pending),
    .rx_done(rx_done), .rx_data(rx_data), .rx_stop(rx_stop), .rx_par(rx_par),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .status(status), .rx_dreg(rx_dreg)
  );

  // driver: inputs were set by the caller at a falling edge; queue the result
  task automatic tick(input logic [7:0] st, input logic [7:0] d, input string req);
    exp_t e;
    e.due = cyc + 1; e.st = st; e.d = d; e.req = req;
    q.push_back(e);
    @(negedge clk);
    tx_start = 0; tx_byte_done = 0; rx_done = 0; cpu_wr = 0; cpu_rd = 0;
  endtask

  task automatic rx(input logic [7:0] d, input logic stp, input logic p);
    rx_done = 1; rx_data = d; rx_stop = stp; rx_par = p;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (status !== e.st || rx_dreg !== e.d) begin
        errors++;
        $display("FAIL %s: status=%h data=%h expected status=%h data=%h",
                 e.req, status, rx_dreg, e.st, e.d);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (status !== 8'h00 || rx_dreg !== 8'h00) begin
      errors++;
      $display("FAIL R1: status=%h data=%h expected status=00 data=00", status, rx_dreg);
    end
    rst_n = 1;
    @(negedge clk);
    tick(8'h00, 8'h00, "R1");
    // reception with correct even parity
    rx(8'h35, 1, 0);                     tick(8'h01, 8'h35, "R8");
    cpu_rd = 1;                          tick(8'h00, 8'h35, "R8");
    // stop 0 and bad even parity
    rx(8'h07, 0, 0);                     tick(8'h19, 8'h07, "R5 R6");
    // reception while full: overrun, data overwritten
    rx(8'h01, 1, 1);                     tick(8'h1D, 8'h01, "R7");
    cpu_wr = 1; cpu_wdata = 8'hFF;       tick(8'h1D, 8'h01, "R9");
    cpu_wr = 1; cpu_wdata = 8'hEF;       tick(8'h0D, 8'h01, "R9");
    cpu_wr = 1; cpu_wdata = 8'h00; cpu_rd = 1; tick(8'h00, 8'h01, "R9 R8");
    // set wins over clearing write
    rx(8'h03, 0, 0); cpu_wr = 1; cpu_wdata = 8'h00; tick(8'h11, 8'h03, "R10");
    // odd parity good, read in same cycle: no overrun
    par_odd = 1;                         tick(8'h11, 8'h03, "R6");
    rx(8'h03, 1, 1); cpu_rd = 1;         tick(8'h11, 8'h03, "R8");
    rx(8'h03, 1, 0); cpu_rd = 1;         tick(8'h19, 8'h03, "R6");
    // both enables off: errors cleared, events ignored
    rx_en = 0; tx_en = 0; rx(8'hAA, 0, 0); tick(8'h01, 8'hAA, "R11");
    rx_en = 1; cpu_rd = 1;               tick(8'h00, 8'hAA, "R11");
    // synchronous mode: no framing or parity
    mode_async = 0; mode_master = 1;     tick(8'h00, 8'hAA, "R12");
    rx(8'h01, 0, 0);                     tick(8'h01, 8'h01, "R12");
    cpu_rd = 1;                          tick(8'h00, 8'h01, "R8");
    // busy in synchronous master
    tx_start = 1;                        tick(8'h20, 8'h01, "R2");
    tx_byte_done = 1; tx_pending = 1;    tick(8'h20, 8'h01, "R3");
    tx_byte_done = 1; tx_pending = 0;    tick(8'h00, 8'h01, "R3");
    // busy in asynchronous mode
    mode_async = 1;                      tick(8'h00, 8'h01, "R3");
    tx_start = 1;                        tick(8'h20, 8'h01, "R2");
    tx_byte_done = 1; tx_pending = 1;    tick(8'h20, 8'h01, "R3");
    tx_byte_done = 1; tx_pending = 0;    tick(8'h00, 8'h01, "R3");
    // synchronous slave
    mode_async = 0; mode_master = 0;     tick(8'h00, 8'h01, "R4");
    tx_start = 1;                        tick(8'h20, 8'h01, "R2");
    tx_byte_done = 1; tx_pending = 1;    tick(8'h00, 8'h01, "R4");
    // busy is read-only; start beats byte-done
    cpu_wr = 1; cpu_wdata = 8'h20;       tick(8'h00, 8'h01, "R2");
    tx_start = 1; tx_byte_done = 1;      tick(8'h20, 8'h01, "R2");
    cpu_wr = 1; cpu_wdata = 8'h00;       tick(8'h20, 8'h01, "R2");
    tx_byte_done = 1;                    tick(8'h00, 8'h01, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule